// File: doc/BRIEF.md
# Byte-Strobed 16-Bit Bus Cycle Sequencer

This block turns requests from an internal port into handshaked cycles on a 16-bit external bus. The external bus has no address bit 0. Each request carries a byte address, a transfer size (byte, word or long), a direction and up to 32 bits of write data. The sequencer checks alignment first and rejects any misaligned word or long request without touching the bus. A byte is selected by one of two lane strobes. A long is carried as two word cycles, the high word first. Every cycle holds its strobes until the target pulls the active-low acknowledge input low.

A target that never acknowledges cannot stall the requester forever. A watchdog counts the clocks in which a cycle is active and the acknowledge is still high. When that count reaches `WDOG_LIMIT`, the watchdog ends the cycle, and the request then completes with a bus error.

The control is one state machine with four states:
- `ST_IDLE`: ready for a request. On an accepted request it goes to `ST_FINISH` if the request is misaligned, and to `ST_SETUP` otherwise.
- `ST_SETUP`: strobes negated. It waits until the acknowledge is high, then goes to `ST_ACTIVE`.
- `ST_ACTIVE`: strobes asserted. When the acknowledge is low, it goes to `ST_SETUP` for the second half of a long, or to `ST_FINISH` otherwise. When the watchdog expires, it goes to `ST_FINISH` with a bus error.
- `ST_FINISH`: drives a one-clock done pulse and returns to `ST_IDLE`.

Top module: `bus_seq16`

## Requirements
- R1: `req_ready` is high only in the idle state. A request is taken on a clock where `req_valid` and `req_ready` are both high. `req_ready` then stays low until `rsp_done`, and `rsp_done` is high for exactly one clock.
- R2: Size code 0 is byte, 1 is word and 2 is long. A byte at an even address asserts only `bus_uds_n`, and a byte at an odd address asserts only `bus_lds_n`. Word and long cycles assert both strobes. The upper lane (bits 15:8) carries the even byte.
- R3: A word or long request at an odd address, and any request with size code 3, runs no bus cycle. It completes on the clock after acceptance with `rsp_aerr` set, and a write of this kind leaves memory unchanged.
- R4: An aligned long runs exactly two bus cycles. The first cycle uses word address `addr[ADDR_W-1:1]` and the second uses that address plus one. A long read returns the first word in bits 31:16 and the second in bits 15:0.
- R5: A byte read returns the selected lane zero-extended in bits 7:0. A word read returns the bus word zero-extended in bits 15:0.
- R6: Write data is driven on `bus_dout`. A byte write puts `wdata[7:0]` on both lanes. A word write drives `wdata[15:0]`. A long write drives `wdata[31:16]` in the first cycle and `wdata[15:0]` in the second. `bus_rw` is 1 for a read and 0 for a write.
- R7: A cycle keeps its strobes asserted, with the address unchanged, until acknowledge is seen low. An acknowledge after `WDOG_LIMIT-2` extra clocks still completes without error.
- R8: A cycle in which acknowledge stays high for `WDOG_LIMIT` consecutive active clocks ends with `rsp_berr` set. In that case `rsp_rdata` is zero and the strobes were asserted for exactly `WDOG_LIMIT` clocks.
- R9: A bus error in the first half of a long cancels the second half, so only one bus cycle runs.
- R10: Between any two bus cycles the strobes are negated for at least one clock. A new cycle starts only when acknowledge is high.
- R11: Each request produces exactly one outcome: plain done, address error, or bus error. `rsp_aerr` and `rsp_berr` are never high without `rsp_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 0 byte, 1 word, 2 long, 3 reserved |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_aerr | output | 1 | Address error, valid with done |
| rsp_berr | output | 1 | Bus error, valid with done |
| rsp_rdata | output | 32 | Read data, valid with a clean read done |
| bus_addr | output | ADDR_W-1 | Word address, bits ADDR_W-1:1 |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_uds_n | output | 1 | Upper (even) byte strobe, active low |
| bus_lds_n | output | 1 | Lower (odd) byte strobe, active low |
| bus_rw | output | 1 | 1 read, 0 write |
| bus_dout | output | 16 | Write data to the bus |
| bus_din | input | 16 | Read data from the bus |
| bus_dtack_n | input | 1 | Data acknowledge, active low |

## Verification
The bench runs every size code, including the reserved code, across eight consecutive addresses. Each case is a write followed by a read-back, checked against a byte-level shadow memory. The odd and even addresses separate correct lane selection from misaligned-request rejection. The long cases show whether the halves are ordered and addressed correctly. The bench varies the acknowledge delay and holds acknowledge low for a while after each cycle, which shows whether the sequencer waits on acknowledge rather than on a fixed count. A target that never acknowledges is used at the watchdog limit and one clock either side of it, with word and long reads. These runs show the exact watchdog length and that a failing first half cancels the second.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_FINISH = 2'd3
    } state_e;

    // A request that must be refused without a bus cycle.
    function automatic logic misaligned(input size_e sz, input logic a0);
        return (sz == SZ_RSVD) || ((sz != SZ_BYTE) && a0);
    endfunction

endpackage

// File: rtl/bseq_lane.sv
module bseq_lane
    import bseq_pkg::*;
(
    input  size_e       size,
    input  logic        addr0,
    input  logic        half,
    input  logic [31:0] wdata,
    output logic        uds_en,
    output logic        lds_en,
    output logic [15:0] dout
);
    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                uds_en = !addr0;
                lds_en = addr0;
                dout   = {wdata[7:0], wdata[7:0]};
            end
            SZ_WORD: begin
                uds_en = 1'b1;
                lds_en = 1'b1;
                dout   = wdata[15:0];
            end
            SZ_LONG: begin
                uds_en = 1'b1;
                lds_en = 1'b1;
                dout   = half ? wdata[15:0] : wdata[31:16];
            end
            SZ_RSVD: begin
                uds_en = 1'b0;
                lds_en = 1'b0;
                dout   = 16'h0000;
            end
        endcase
    end
endmodule

// File: rtl/bseq_wdog.sv
module bseq_wdog #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    assign expired = tick && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (tick && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bseq_gather.sv
module bseq_gather
    import bseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        capture,
    input  size_e       size,
    input  logic        addr0,
    input  logic        half,
    input  logic [15:0] din,
    output logic [31:0] rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (clear) begin
            rdata <= '0;
        end else if (capture) begin
            unique case (size)
                SZ_BYTE: rdata <= {24'h0, addr0 ? din[7:0] : din[15:8]};
                SZ_WORD: rdata <= {16'h0, din};
                SZ_LONG: begin
                    if (half) rdata[15:0]  <= din;
                    else      rdata[31:16] <= din;
                end
                SZ_RSVD: rdata <= rdata;
            endcase
        end
    end
endmodule

// File: rtl/bus_seq16.sv
module bus_seq16
    import bseq_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int WDOG_LIMIT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    output logic              rsp_done,
    output logic              rsp_aerr,
    output logic              rsp_berr,
    output logic [31:0]       rsp_rdata,
    output logic [ADDR_W-1:1] bus_addr,
    output logic              bus_as_n,
    output logic              bus_uds_n,
    output logic              bus_lds_n,
    output logic              bus_rw,
    output logic [15:0]       bus_dout,
    input  logic [15:0]       bus_din,
    input  logic              bus_dtack_n
);
    localparam int WA_W = ADDR_W - 1;

    state_e            state, nxt;
    logic [ADDR_W-1:0] addr_q;
    size_e             size_q;
    logic              wr_q;
    logic [31:0]       wdata_q;
    logic              half_q;
    logic              aerr_q;
    logic              berr_q;

    logic        accept;
    logic        bad_req;
    logic        active;
    logic        acked;
    logic        expired;
    logic        uds_en;
    logic        lds_en;
    logic [15:0] lane_dout;
    logic [31:0] gathered;

    assign accept  = (state == ST_IDLE) && req_valid;
    assign bad_req = misaligned(size_e'(req_size), req_addr[0]);
    assign active  = (state == ST_ACTIVE);
    assign acked   = active && !bus_dtack_n;

    bseq_lane u_lane (
        .size   (size_q),
        .addr0  (addr_q[0]),
        .half   (half_q),
        .wdata  (wdata_q),
        .uds_en (uds_en),
        .lds_en (lds_en),
        .dout   (lane_dout)
    );

    bseq_wdog #(.LIMIT(WDOG_LIMIT)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!active),
        .tick    (active && bus_dtack_n),
        .expired (expired)
    );

    bseq_gather u_gather (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .capture (acked && !wr_q),
        .size    (size_q),
        .addr0   (addr_q[0]),
        .half    (half_q),
        .din     (bus_din),
        .rdata   (gathered)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) nxt = bad_req ? ST_FINISH : ST_SETUP;
            end
            ST_SETUP: begin
                if (bus_dtack_n) nxt = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (!bus_dtack_n)
                    nxt = (size_q == SZ_LONG && !half_q) ? ST_SETUP : ST_FINISH;
                else if (expired)
                    nxt = ST_FINISH;
            end
            ST_FINISH: nxt = ST_IDLE;
        endcase
    end

    // Request context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            size_q  <= SZ_BYTE;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            half_q  <= 1'b0;
            aerr_q  <= 1'b0;
            berr_q  <= 1'b0;
        end else if (accept) begin
            addr_q  <= req_addr;
            size_q  <= size_e'(req_size);
            wr_q    <= req_write;
            wdata_q <= req_wdata;
            half_q  <= 1'b0;
            aerr_q  <= bad_req;
            berr_q  <= 1'b0;
        end else if (acked && size_q == SZ_LONG && !half_q) begin
            half_q  <= 1'b1;
        end else if (active && bus_dtack_n && expired) begin
            berr_q  <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        req_ready = (state == ST_IDLE);
        bus_as_n  = !active;
        bus_uds_n = !(active && uds_en);
        bus_lds_n = !(active && lds_en);
        bus_rw    = !wr_q;
        bus_dout  = wr_q ? lane_dout : 16'h0000;
        bus_addr  = addr_q[ADDR_W-1:1] + {{(WA_W-1){1'b0}}, half_q};
        rsp_done  = (state == ST_FINISH);
        rsp_aerr  = rsp_done && aerr_q;
        rsp_berr  = rsp_done && berr_q;
        rsp_rdata = (rsp_done && !aerr_q && !berr_q && !wr_q) ? gathered : 32'h0;
    end
endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
    parameter int LIMIT  = 64,
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              rsp_aerr,
    input logic              rsp_berr,
    input logic [ADDR_W-1:1] bus_addr,
    input logic              bus_as_n,
    input logic              bus_uds_n,
    input logic              bus_lds_n,
    input logic              bus_dtack_n
);
    localparam int RUN_W = $clog2(LIMIT + 2);

    logic [RUN_W-1:0] wait_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       wait_run <= '0;
        else if (bus_as_n)                wait_run <= '0;
        else if (bus_dtack_n)             wait_run <= wait_run + 1'b1;
    end

    // R1
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_as_n |-> !req_ready);

    // R2
    strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_as_n |-> (bus_uds_n && bus_lds_n));

    // R2
    strobe_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_as_n |-> !(bus_uds_n && bus_lds_n));

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n && $past(!bus_as_n)) |-> $stable(bus_addr));

    // R8
    wdog_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_run <= RUN_W'(LIMIT));

    // R10
    start_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_as_n) |-> $past(bus_dtack_n));

    // R11
    flag_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_aerr || rsp_berr) |-> (rsp_done && !(rsp_aerr && rsp_berr)));

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
endmodule

bind bus_seq16 bseq_chk #(.LIMIT(WDOG_LIMIT), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done),
    .rsp_aerr    (rsp_aerr),
    .rsp_berr    (rsp_berr),
    .bus_addr    (bus_addr),
    .bus_as_n    (bus_as_n),
    .bus_uds_n   (bus_uds_n),
    .bus_lds_n   (bus_lds_n),
    .bus_dtack_n (bus_dtack_n)
);

// File: tb/bus_seq16_tb.sv
module bus_seq16_tb;
    localparam int AW  = 8;
    localparam int LIM = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic          req_write = 1'b0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_done, rsp_aerr, rsp_berr;
    logic [31:0]   rsp_rdata;
    logic [AW-1:1] bus_addr;
    logic          bus_as_n, bus_uds_n, bus_lds_n, bus_rw;
    logic [15:0]   bus_dout, bus_din;
    logic          bus_dtack_n = 1'b1;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    bus_seq16 #(.ADDR_W(AW), .WDOG_LIMIT(LIM)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
        .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_aerr(rsp_aerr),
        .rsp_berr(rsp_berr), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
        .bus_as_n(bus_as_n), .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n),
        .bus_rw(bus_rw), .bus_dout(bus_dout), .bus_din(bus_din),
        .bus_dtack_n(bus_dtack_n)
    );

    // Target model
    logic [15:0] mem [16];
    logic [7:0]  shadow [32];
    int  dly = 0;
    int  rel_lag = 0;
    bit  noack = 1'b0;
    int  asc = 0;
    int  lag_cnt = 0;

    assign bus_din = mem[bus_addr[4:1]];

    always @(posedge clk) begin
        if (!bus_as_n) begin
            if (!bus_dtack_n && !bus_rw) begin
                if (!bus_uds_n) mem[bus_addr[4:1]][15:8] <= bus_dout[15:8];
                if (!bus_lds_n) mem[bus_addr[4:1]][7:0]  <= bus_dout[7:0];
            end
            asc <= asc + 1;
            if (!noack && asc >= dly) bus_dtack_n <= 1'b0;
            lag_cnt <= rel_lag;
        end else begin
            asc <= 0;
            if (lag_cnt > 0) lag_cnt <= lag_cnt - 1;
            else             bus_dtack_n <= 1'b1;
        end
    end

    // Bus monitor
    int  ncyc = 0;
    int  run = 0;
    int  last_run = 0;
    int  gapviol = 0;
    bit  prev_as = 1'b1;
    logic [AW-1:1] first_addr, last_addr;
    logic last_uds, last_lds;
    logic [15:0] first_dout, last_dout;

    always @(negedge clk) begin
        if (!bus_as_n) begin
            run <= run + 1;
            if (prev_as) begin
                ncyc <= ncyc + 1;
                if (!bus_dtack_n) gapviol <= gapviol + 1;
                if (ncyc_mark == ncyc) begin
                    first_addr <= bus_addr;
                    first_dout <= bus_dout;
                end
                last_addr <= bus_addr;
                last_dout <= bus_dout;
                last_uds  <= bus_uds_n;
                last_lds  <= bus_lds_n;
            end
        end else begin
            if (run > 0) last_run <= run;
            run <= 0;
        end
        prev_as <= bus_as_n;
    end

    int ncyc_mark = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    bit          r_ae, r_be;
    logic [31:0] r_rd;
    int          r_cyc;

    task automatic do_req(input logic [AW-1:0] a, input logic [1:0] sz,
                          input logic wr, input logic [31:0] wd);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        ncyc_mark = ncyc;
        req_addr  = a;
        req_size  = sz;
        req_write = wr;
        req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        // R1: ready low right after acceptance
        check(!req_ready, "R1 ready after accept", {31'b0, req_ready}, 32'h0);
        while (!rsp_done) @(negedge clk);
        r_ae = rsp_aerr;
        r_be = rsp_berr;
        r_rd = rsp_rdata;
        @(negedge clk);
        // R1: done is a single-clock pulse
        check(!rsp_done, "R1 done pulse", {31'b0, rsp_done}, 32'h0);
        r_cyc = ncyc - ncyc_mark;
    endtask

    function automatic logic [31:0] expect_read(input int a, input int sz);
        logic [31:0] v;
        v = 32'h0;
        if (sz == 0) v = {24'h0, shadow[a % 32]};
        else if (sz == 1) v = {16'h0, shadow[a % 32], shadow[(a + 1) % 32]};
        else v = {shadow[a % 32], shadow[(a + 1) % 32],
                  shadow[(a + 2) % 32], shadow[(a + 3) % 32]};
        return v;
    endfunction

    initial begin : watchdog
        #(8 * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 16; i++) begin
            mem[i] = 16'(i * 16'h1357 + 16'h0A0B);
            shadow[2 * i]     = mem[i][15:8];
            shadow[2 * i + 1] = mem[i][7:0];
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_ready && bus_as_n && !rsp_done, "R1 reset state",
              {29'b0, req_ready, bus_as_n, rsp_done}, 32'h6);
        rst_n = 1'b1;
        @(negedge clk);

        for (int sz = 0; sz < 4; sz++) begin
            for (int a = 0; a < 8; a++) begin
                bit          bad;
                int          ecyc;
                logic [31:0] wd;
                bad  = (sz == 3) || (sz != 0 && a[0]);
                ecyc = bad ? 0 : ((sz == 2) ? 2 : 1);
                wd   = 32'hC0DE0000 ^ 32'(sz * 32'h01110111) ^ 32'(a * 32'h10203);
                dly     = a % 3;
                rel_lag = (a % 2) * 2;

                do_req(AW'(a), 2'(sz), 1'b1, wd);
                // R3 / R11: outcome flags
                check(r_ae == bad && !r_be, "R3 R11 write flags",
                      {30'b0, r_ae, r_be}, {30'b0, bad, 1'b0});
                // R4 / R3: number of bus cycles
                check(r_cyc == ecyc, "R4 R3 write cycle count", 32'(r_cyc), 32'(ecyc));
                if (!bad) begin
                    // R4: word addresses of the halves
                    check(first_addr == (AW-1)'(a / 2) && last_addr == (AW-1)'(a / 2 + ecyc - 1),
                          "R4 half addresses", {16'(first_addr), 16'(last_addr)},
                          {16'(a / 2), 16'(a / 2 + ecyc - 1)});
                    // R2: strobes of the last cycle
                    if (sz == 0)
                        check(last_uds == a[0] && last_lds == !a[0], "R2 byte strobes",
                              {30'b0, last_uds, last_lds}, {30'b0, a[0], !a[0]});
                    else
                        check(!last_uds && !last_lds, "R2 word strobes",
                              {30'b0, last_uds, last_lds}, 32'h0);
                    // R6: write data on the bus
                    if (sz == 0)
                        check(last_dout == {wd[7:0], wd[7:0]}, "R6 byte lanes",
                              {16'h0, last_dout}, {16'h0, wd[7:0], wd[7:0]});
                    else if (sz == 2)
                        check(first_dout == wd[31:16] && last_dout == wd[15:0],
                              "R6 long halves", {first_dout, last_dout}, wd);
                    if (sz == 0) shadow[a] = wd[7:0];
                    else if (sz == 1) begin
                        shadow[a] = wd[15:8]; shadow[a + 1] = wd[7:0];
                    end else begin
                        shadow[a] = wd[31:24]; shadow[a + 1] = wd[23:16];
                        shadow[a + 2] = wd[15:8]; shadow[a + 3] = wd[7:0];
                    end
                end

                do_req(AW'(a), 2'(sz), 1'b0, 32'h0);
                check(r_ae == bad && !r_be, "R3 R11 read flags",
                      {30'b0, r_ae, r_be}, {30'b0, bad, 1'b0});
                if (!bad) begin
                    // R5 / R4 / R3: read data against shadow (misaligned writes left it alone)
                    check(r_rd == expect_read(a, sz), "R5 R4 R3 read data", r_rd,
                          expect_read(a, sz));
                end else begin
                    check(r_rd == 32'h0 && r_cyc == 0, "R3 no bus cycle on reject",
                          32'(r_cyc), 32'h0);
                end
                // R10: no cycle started with acknowledge low
                check(gapviol == 0, "R10 start gap", 32'(gapviol), 32'h0);
            end
        end

        // R7: slowest acknowledge that still succeeds
        rel_lag = 0;
        dly = LIM - 2;
        do_req(8'd12, 2'd1, 1'b0, 32'h0);
        check(!r_be && !r_ae && r_rd == expect_read(12, 1), "R7 late ack ok", r_rd,
              expect_read(12, 1));
        check(last_run == LIM, "R7 strobe hold length", 32'(last_run), 32'(LIM));

        // R8: one clock later becomes a bus error
        dly = LIM - 1;
        do_req(8'd12, 2'd1, 1'b0, 32'h0);
        check(r_be && !r_ae && r_rd == 32'h0, "R8 limit berr",
              {r_rd[29:0], r_ae, r_be}, 32'h1);

        // R8: no acknowledge at all
        noack = 1'b1;
        do_req(8'd4, 2'd1, 1'b0, 32'h0);
        check(r_be && !r_ae && r_rd == 32'h0, "R8 noack word berr",
              {r_rd[29:0], r_ae, r_be}, 32'h1);
        check(last_run == LIM, "R8 strobe length on timeout", 32'(last_run), 32'(LIM));

        // R9: long cancelled after first half
        do_req(8'd8, 2'd2, 1'b0, 32'h0);
        check(r_be && r_rd == 32'h0, "R9 long berr", {31'b0, r_be}, 32'h1);
        check(r_cyc == 1, "R9 second half cancelled", 32'(r_cyc), 32'h1);

        // R8 / R9: failed long write changes nothing
        do_req(8'd16, 2'd2, 1'b1, 32'hFFFFFFFF);
        check(r_be && r_cyc == 1, "R9 long write berr", 32'(r_cyc), 32'h1);
        noack = 1'b0;
        dly = 0;
        do_req(8'd16, 2'd2, 1'b0, 32'h0);
        check(!r_be && r_rd == expect_read(16, 2), "R4 long read after cancel", r_rd,
              expect_read(16, 2));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule